// File: doc/BRIEF.md
# Power-Retained Four-Bit State Register

This block is a four-bit register clocked by a slow external state clock. Every value it captures is copied into an external nonvolatile cell array. When power comes back, the block reads that array and drives the saved value again. Software never has to read or rewrite the setting. All logic runs on a free-running system clock. The external state clock, the enable and the data inputs are synchronised into that domain. A rising edge of the state clock is found by comparing the synchronised level with its previous value.

Pulling the enable low stops all activity. The outputs float, and no write to the array may start. When the enable rises again, the block issues one read to the array and waits for the array's done pulse. It then drives the value read back. After that it waits a fixed number of system cycles before it accepts a new state-clock edge. The array port carries one request at a time. A capture that arrives while a write is still in flight is held as a single pending value, so the most recent capture is always the one written last. A capture that matches the value already stored, or already queued, starts no write.

Top module: `nv_quad_state_reg`

## Requirements
- R1: In the run phase, a rising edge of `st_clk` copies `d` into `q`. `q` shows the new value no more than 6 system cycles after the edge reaches the pin.
- R2: While `st_clk` stays at one level, `q` does not follow changes on `d`.
- R3: While `en` is low, `q_oe` is 0, which means the outputs float. `q_oe` falls no more than 4 system cycles after `en` falls.
- R4: While `en` is low, `st_clk` edges are ignored and no write request (`nv_req`=1 with `nv_we`=1) is started.
- R5: When `en` rises, one read request (`nv_req`=1 with `nv_we`=0) is issued. `q_oe` stays 0 until the read's `nv_done` arrives. After that, `q` equals `nv_rdata` and `q_oe` is 1, even if power loss (reset) had cleared the register.
- R6: `st_clk` edges that arrive before `HOLD_CYC` system cycles have passed since the start of the restore are discarded. Edges after that window are captured.
- R7: A capture issues a write of the new value only when it differs from the value last written or already queued. A capture of an equal value issues no write.
- R8: A capture that arrives while a write is busy becomes pending and replaces any earlier pending value. If the capture equals the value being written, the pending value is cancelled. The latest capture is always the last value written.
- R9: `nv_req` is a single-cycle pulse. No new request is issued until `nv_done` has answered the previous one.
- R10: While `rst_n` is low and right after it is released, `q_oe` is 0 and `nv_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low reset, used to model power loss |
| en | input | 1 | Active-high enable, asynchronous |
| st_clk | input | 1 | External state clock, asynchronous |
| d | input | W | Data to capture |
| q | output | W | Held state |
| q_oe | output | 1 | Output enable; 0 means the outputs float |
| nv_req | output | 1 | One-cycle request to the array |
| nv_we | output | 1 | 1 = write, 0 = read; valid with `nv_req` |
| nv_wdata | output | W | Data to write |
| nv_rdata | input | W | Read data, valid with `nv_done` |
| nv_done | input | 1 | One-cycle completion pulse from the array |

## Verification
The bench drives a single capture and checks that `q` follows `d`. It then changes `d` with no clock edge, which separates a level-sensitive design from an edge-triggered one. It repeats a capture with the same value, which shows whether a design skips a write that is not needed. Bursts of captures spaced closer than the array's write latency show whether superseded values are dropped, and a burst that returns to the in-flight value shows whether the pending value is cancelled. Edges sent inside the hold-off window, and edges sent while the enable is low, must leave both `q` and the write stream unchanged. A reset taken between two enable periods shows that the restored value comes from the array and not from the register.

// File: rtl/nvq_pkg.sv
package nvq_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RESTORE = 2'd1,
    ST_HOLDOFF = 2'd2,
    ST_RUN     = 2'd3
  } nvq_state_e;
endpackage

// File: rtl/nvq_sync.sv
module nvq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/nvq_ctrl.sv
module nvq_ctrl #(
  parameter int HOLD_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic rd_done,
  output logic rd_start,
  output logic load_restore,
  output logic run,
  output logic oe,
  output logic holdoff
);
  import nvq_pkg::*;

  localparam int CW = $clog2(HOLD_CYC + 1) + 1;

  nvq_state_e st_q, st_d;
  logic [CW-1:0] cnt_q;

  function automatic logic window_over(input logic [CW-1:0] c);
    return (c >= CW'(HOLD_CYC - 1));
  endfunction

  always_comb begin
    st_d         = st_q;
    rd_start     = 1'b0;
    load_restore = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (en_s) begin
          st_d     = ST_RESTORE;
          rd_start = 1'b1;
        end
      end
      ST_RESTORE: begin
        if (rd_done) begin
          load_restore = 1'b1;
          if (!en_s)                  st_d = ST_OFF;
          else if (window_over(cnt_q)) st_d = ST_RUN;
          else                        st_d = ST_HOLDOFF;
        end
      end
      ST_HOLDOFF: begin
        if (!en_s)                   st_d = ST_OFF;
        else if (window_over(cnt_q)) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (!en_s) st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_OFF)
        cnt_q <= '0;
      else if (!window_over(cnt_q))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign run     = (st_q == ST_RUN);
  assign holdoff = (st_q == ST_HOLDOFF);
  assign oe      = (st_q == ST_HOLDOFF) || (st_q == ST_RUN);

  AST_FLOAT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !oe); // R3
  AST_RUN_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q >= CW'(HOLD_CYC - 1))); // R6
endmodule

// File: rtl/nvq_commit.sv
module nvq_commit #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         allow,
  input  logic         cap_valid,
  input  logic [W-1:0] cap_data,
  input  logic         rd_start,
  output logic         rd_done,
  output logic [W-1:0] rd_data,
  output logic         nv_req,
  output logic         nv_we,
  output logic [W-1:0] nv_wdata,
  input  logic [W-1:0] nv_rdata,
  input  logic         nv_done
);
  logic         busy_q, op_we_q, rd_want_q, pend_q;
  logic [W-1:0] pend_data_q, shadow_q;
  logic         issue_wr, issue_rd;
  logic         base_pend;
  logic [W-1:0] base_shadow;
  logic [W:0]   merged;

  // Returns {pending, data} after folding one capture into the queue state.
  function automatic logic [W:0] fold_capture(input logic p, input logic [W-1:0] pd,
                                              input logic [W-1:0] sh, input logic [W-1:0] c);
    logic [W-1:0] last;
    last = p ? pd : sh;
    if (c == last)      return {p, pd};
    else if (c == sh)   return {1'b0, pd};
    else                return {1'b1, c};
  endfunction

  assign issue_wr    = !busy_q && pend_q && allow;
  assign issue_rd    = !busy_q && !pend_q && rd_want_q;
  assign nv_req      = issue_wr || issue_rd;
  assign nv_we       = issue_wr;
  assign nv_wdata    = pend_data_q;
  assign rd_done     = busy_q && !op_we_q && nv_done;
  assign rd_data     = nv_rdata;

  assign base_shadow = issue_wr ? pend_data_q : shadow_q;
  assign base_pend   = pend_q && !issue_wr;
  assign merged      = fold_capture(base_pend, pend_data_q, base_shadow, cap_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      op_we_q     <= 1'b0;
      rd_want_q   <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      shadow_q    <= '0;
    end else begin
      if (rd_start)      rd_want_q <= 1'b1;
      else if (issue_rd) rd_want_q <= 1'b0;

      if (nv_req) begin
        busy_q  <= 1'b1;
        op_we_q <= nv_we;
      end else if (nv_done) begin
        busy_q  <= 1'b0;
      end

      if (rd_done) shadow_q <= nv_rdata;
      else         shadow_q <= base_shadow;

      if (cap_valid) begin
        pend_q      <= merged[W];
        pend_data_q <= merged[W-1:0];
      end else begin
        pend_q      <= base_pend;
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |=> !nv_req); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !nv_done) |-> !nv_req); // R9
  AST_WRITE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_we) |-> (nv_wdata != shadow_q)); // R7
  AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_we) |-> allow); // R4
endmodule

// File: rtl/nv_quad_state_reg.sv
module nv_quad_state_reg #(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 500
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         st_clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_oe,
  output logic         nv_req,
  output logic         nv_we,
  output logic [W-1:0] nv_wdata,
  input  logic [W-1:0] nv_rdata,
  input  logic         nv_done
);
  localparam int SW = W + 2;

  logic [SW-1:0] raw_in, syn_out;
  logic          en_s, stc_s, stc_prev_q, st_rise;
  logic [W-1:0]  d_s, live_q, rd_data;
  logic          rd_start, rd_done, load_restore, run, holdoff, cap_fire;

  assign raw_in = {en, st_clk, d};

  nvq_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_out)
  );

  assign en_s  = syn_out[SW-1];
  assign stc_s = syn_out[SW-2];
  assign d_s   = syn_out[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stc_prev_q <= 1'b0;
    else        stc_prev_q <= stc_s;
  end

  assign st_rise  = stc_s && !stc_prev_q;
  assign cap_fire = st_rise && run && en_s;

  nvq_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .rd_done(rd_done),
    .rd_start(rd_start), .load_restore(load_restore), .run(run),
    .oe(q_oe), .holdoff(holdoff)
  );

  nvq_commit #(.W(W)) u_commit (
    .clk(clk), .rst_n(rst_n), .allow(en_s),
    .cap_valid(cap_fire), .cap_data(d_s),
    .rd_start(rd_start), .rd_done(rd_done), .rd_data(rd_data),
    .nv_req(nv_req), .nv_we(nv_we), .nv_wdata(nv_wdata),
    .nv_rdata(nv_rdata), .nv_done(nv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            live_q <= '0;
    else if (load_restore) live_q <= rd_data;
    else if (cap_fire)     live_q <= d_s;
  end

  assign q = live_q;

  AST_HOLDOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    holdoff |=> $stable(q)); // R6
  AST_STEADY_CLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_rise && !rd_done) |=> $stable(q)); // R2
  AST_OFF_IGNORES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !rd_done) |=> $stable(q)); // R4
endmodule

// File: tb/nv_quad_state_reg_tb.sv
module nv_quad_state_reg_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic st_clk = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q, nv_wdata;
  logic [W-1:0] nv_rdata = '0;
  logic q_oe, nv_req, nv_we;
  logic nv_done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int wr_seen = 0;
  int lat = 20;
  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  nv_quad_state_reg u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .st_clk(st_clk), .d(d),
    .q(q), .q_oe(q_oe), .nv_req(nv_req), .nv_we(nv_we), .nv_wdata(nv_wdata),
    .nv_rdata(nv_rdata), .nv_done(nv_done)
  );

  // behavioural nonvolatile array
  logic [W-1:0] mem = 4'h5;
  logic mbusy = 1'b0, mwe = 1'b0;
  logic [W-1:0] mwdata = '0;
  int mcnt = 0;
  int r9_bad = 0;
  logic prev_req = 1'b0;

  always @(posedge clk) begin
    nv_done <= 1'b0;
    if (!rst_n) begin
      mbusy <= 1'b0;
    end else if (mbusy) begin
      if (nv_req) r9_bad <= r9_bad + 1;
      if (mcnt == 1) begin
        nv_done <= 1'b1;
        mbusy   <= 1'b0;
        if (mwe) mem <= mwdata;
        else     nv_rdata <= mem;
      end
      mcnt <= mcnt - 1;
    end else if (nv_req) begin
      mbusy  <= 1'b1;
      mcnt   <= lat;
      mwe    <= nv_we;
      mwdata <= nv_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the next expected commit
  always @(negedge clk) begin
    if (rst_n) begin
      if (nv_req && prev_req) chk(1'b0, "R9 request longer than one cycle", 1, 0);
      prev_req = nv_req;
      if (nv_req && nv_we) begin
        wr_seen++;
        if (exp_q.size() == 0)
          chk(1'b0, "R7/R8 unexpected write", {28'd0, nv_wdata}, 32'hFFFF);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(nv_wdata == e, "R8 write order", {28'd0, nv_wdata}, {28'd0, e});
        end
      end
    end else begin
      prev_req = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [W-1:0] v, input int half);
    d = v;
    cyc(1);
    st_clk = 1'b1;
    cyc(half);
    st_clk = 1'b0;
    cyc(half);
  endtask

  task automatic expect_wr(input logic [W-1:0] v);
    exp_q.push_back(v);
  endtask

  initial begin
    int wbase;
    cyc(3);
    chk(q_oe == 1'b0, "R10 q_oe in reset", q_oe, 0);
    chk(nv_req == 1'b0, "R10 nv_req in reset", nv_req, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(q_oe == 1'b0 && nv_req == 1'b0, "R10 after release", {q_oe, nv_req}, 0);

    // R5: restore from preloaded array
    en = 1'b1;
    cyc(8);
    chk(q_oe == 1'b0, "R5 floating before done", q_oe, 0);
    cyc(40);
    chk(q_oe == 1'b1, "R5 oe after restore", q_oe, 1);
    chk(q == 4'h5, "R5 restored value", q, 5);

    // R6: edge inside hold-off window
    pulse(4'h3, 4);
    cyc(8);
    chk(q == 4'h5, "R6 early edge discarded", q, 5);
    chk(wr_seen == 0, "R6 no write from early edge", wr_seen, 0);
    cyc(600);

    // R1 and R7
    expect_wr(4'h3);
    pulse(4'h3, 4);
    cyc(6);
    chk(q == 4'h3, "R1 capture", q, 3);
    cyc(40);
    // R2: data change without an edge
    d = 4'h9;
    cyc(20);
    chk(q == 4'h3, "R2 steady clock holds", q, 3);
    // R7: same value again
    wbase = wr_seen;
    pulse(4'h3, 4);
    cyc(40);
    chk(wr_seen == wbase, "R7 equal capture no write", wr_seen, wbase);

    // R8: burst, middle value superseded
    expect_wr(4'h7);
    expect_wr(4'h1);
    pulse(4'h7, 2);
    pulse(4'h8, 2);
    pulse(4'h1, 2);
    cyc(80);
    chk(q == 4'h1, "R8 q holds latest", q, 1);
    chk(mem == 4'h1, "R8 latest committed last", mem, 1);

    // R8: return to in-flight value cancels pending
    expect_wr(4'h2);
    pulse(4'h2, 2);
    pulse(4'h6, 2);
    pulse(4'h2, 2);
    cyc(80);
    chk(q == 4'h2, "R8 cancel q", q, 2);
    chk(exp_q.size() == 0 && mem == 4'h2, "R8 cancel no extra write", mem, 2);

    // R3 and R4
    en = 1'b0;
    cyc(4);
    chk(q_oe == 1'b0, "R3 float when disabled", q_oe, 0);
    wbase = wr_seen;
    pulse(4'hE, 4);
    cyc(40);
    chk(wr_seen == wbase, "R4 no write when disabled", wr_seen, wbase);
    chk(q_oe == 1'b0, "R3 still floating", q_oe, 0);
    en = 1'b1;
    cyc(60);
    chk(q == 4'h2 && q_oe == 1'b1, "R4 edge ignored, restore old", q, 2);
    cyc(600);

    // R5: power loss between enable periods
    expect_wr(4'hA);
    pulse(4'hA, 4);
    cyc(60);
    en = 1'b0;
    cyc(4);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(q_oe == 1'b0, "R10 after power loss", q_oe, 0);
    en = 1'b1;
    cyc(60);
    chk(q == 4'hA && q_oe == 1'b1, "R5 restored after power loss", q, 4'hA);

    chk(r9_bad == 0, "R9 request while busy", r9_bad, 0);
    chk(exp_q.size() == 0, "R7 all expected writes seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule